// File: doc/BRIEF.md
# Indexed Pattern Bank Register File

This block sits on the cartridge side of a video system and decides which part of a large pattern ROM the picture processor sees. The pattern space is cut into 2 KiB windows, and each window has a bank slot. The host CPU loads a slot in two steps. First it writes a slot index to the select address. Then it writes a bank number to the data address, and that number goes into the slot chosen by the index stored last. Each picture-processor pattern fetch is translated at once into a physical ROM address, using the slot that owns the window.

The block also holds a scanline interrupt request. An external per-line pulse (generated near dot 260 of a line) raises it. It stays high until the CPU writes any value to the acknowledge address. Because the select write changes no mapping, software can issue it early. Only the data write then has to land inside the horizontal-blank window.

Top module: `chr_bank_regs`

## Requirements
- R1: After reset every slot holds bank 0 and `irq_o` is low, so `chr_addr_o` equals `{7'b0, ppu_addr_i[10:0]}`.
- R2: A write to address 16'h8000 stores a slot index and leaves the translation of every window unchanged.
- R3: A write to address 16'h8001 loads the written bank number into the slot named by the most recently stored index. The index persists, so repeated data writes keep hitting the same slot.
- R4: `ppu_addr_i[12:11]` picks the slot (0: 16'h0000, 1: 16'h0800, 2: 16'h1000, 3: 16'h1800). `ppu_addr_i[13]` has no effect on the translation.
- R5: The output is `{bank[7:1], ppu_addr_i[10:0]}`, so bit 0 of a written bank number is ignored and each slot selects an even 1 KiB page pair.
- R6: A data write keeps the old translation until its clock edge and gives the new one from the following cycle onward.
- R7: A one-cycle high on `scanline_i` raises `irq_o` from the next cycle. `irq_o` then stays high until it is acknowledged.
- R8: A write of any value to 16'hE000 clears `irq_o` from the next cycle. If `scanline_i` is high in that same cycle, the request stays raised.
- R9: A cycle with `cpu_wr_i` low, or a write to any other address, changes neither slots, index nor `irq_o`.
- R10: Only bits [1:0] of the select write form the index. Higher bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU write address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_wr_i | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr_i | input | 14 | Picture-processor pattern address |
| scanline_i | input | 1 | Per-line event pulse |
| chr_addr_o | output | 18 | Physical pattern-ROM address |
| irq_o | output | 1 | Pending scanline interrupt request |

## Verification
All four slots are loaded with distinct bank values, and then every window is read. This catches swapped or aliased slots, and a set bank low bit shows whether that bit is dropped. The select index is written with its high bits set, and then a data write goes to the same slot twice. This separates a stored index from one derived from the data. A data write is observed on both sides of its clock edge to pin down the one-cycle latency. The interrupt is raised, held across idle cycles, acknowledged with arbitrary data, and hit by a pulse and an acknowledge in the same cycle. Writes with the strobe low and writes to nearby addresses must leave everything as it was.

// File: rtl/chr_bank_pkg.sv
package chr_bank_pkg;
  typedef struct packed {
    logic sel;
    logic load;
    logic ack;
  } wr_cmd_t;
endpackage

// File: rtl/cpu_wr_decode.sv
module cpu_wr_decode
  import chr_bank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SEL_ADDR  = 16'h8000,
  parameter logic [ADDR_W-1:0] LOAD_ADDR = 16'h8001,
  parameter logic [ADDR_W-1:0] ACK_ADDR  = 16'hE000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output wr_cmd_t           cmd_o
);
  always_comb begin
    cmd_o.sel  = wr_i && (addr_i == SEL_ADDR);
    cmd_o.load = wr_i && (addr_i == LOAD_ADDR);
    cmd_o.ack  = wr_i && (addr_i == ACK_ADDR);
  end
endmodule

// File: rtl/bank_slots.sv
module bank_slots
  import chr_bank_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS),
  localparam int unsigned PAGE_W   = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_cmd_t           cmd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  rd_slot_i,
  output logic [PAGE_W-1:0] page_o
);
  logic [IDX_W-1:0]                idx_q;
  logic [NUM_SLOTS-1:0][PAGE_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idx_q <= '0;
    else if (cmd_i.sel) idx_q <= data_i[IDX_W-1:0];
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[s] <= '0;
      else if (cmd_i.load && idx_q == IDX_W'(s))
        slot_q[s] <= data_i[DATA_W-1:1]; // bank bit 0 dropped: 2 KiB granularity
    end
  end

  assign page_o = slot_q[rd_slot_i];

  assert_sel_no_remap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.sel |=> $stable(slot_q));

  assert_load_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.load |=> slot_q[$past(idx_q)] == $past(data_i[DATA_W-1:1]));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i.load && !cmd_i.sel |=> $stable(slot_q) && $stable(idx_q));
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raise_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_q <= 1'b0;
    else if (raise_i) irq_q <= 1'b1; // a fresh event beats a same-cycle ack
    else if (ack_i)   irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  assert_raise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_i |=> irq_q);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !ack_i |=> irq_q);

  assert_ack_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !raise_i |=> !irq_q);
endmodule

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
  import chr_bank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PPU_W     = 14,
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned WIN_W     = 11,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS),
  localparam int unsigned PAGE_W   = DATA_W - 1,
  localparam int unsigned PHYS_W   = PAGE_W + WIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic              cpu_wr_i,
  input  logic [PPU_W-1:0]  ppu_addr_i,
  input  logic              scanline_i,
  output logic [PHYS_W-1:0] chr_addr_o,
  output logic              irq_o
);
  wr_cmd_t           cmd;
  logic [PAGE_W-1:0] page;
  logic [IDX_W-1:0]  slot;
  logic              unused_hi;

  assign slot      = ppu_addr_i[WIN_W +: IDX_W];
  assign unused_hi = ^ppu_addr_i[PPU_W-1:WIN_W+IDX_W];

  cpu_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(cpu_addr_i), .wr_i(cpu_wr_i), .cmd_o(cmd)
  );

  bank_slots #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_slots (
    .clk_i, .rst_ni, .cmd_i(cmd), .data_i(cpu_data_i),
    .rd_slot_i(slot), .page_o(page)
  );

  irq_latch u_irq (
    .clk_i, .rst_ni, .raise_i(scanline_i), .ack_i(cmd.ack), .irq_o
  );

  assign chr_addr_o = {page, ppu_addr_i[WIN_W-1:0]};
endmodule

// File: tb/chr_bank_regs_tb_top.sv
module chr_bank_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        scanline = 1'b0;
  logic [17:0] chr_addr;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [6:0] exp_page [4];

  always #2.5 clk = ~clk;

  chr_bank_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(cpu_addr), .cpu_data_i(cpu_data),
    .cpu_wr_i(cpu_wr), .ppu_addr_i(ppu_addr), .scanline_i(scanline),
    .chr_addr_o(chr_addr), .irq_o(irq)
  );

  function automatic logic [17:0] exp_phys(logic [13:0] a);
    return {exp_page[a[12:11]], a[10:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic chk_all_windows(string req);
    for (int w = 0; w < 4; w++) begin
      ppu_addr = 14'(w * 14'h800 + 14'h2A5);
      #0.5;
      chk(req, 32'(chr_addr), 32'(exp_phys(ppu_addr)));
    end
  endtask

  task automatic t_reset;
    for (int w = 0; w < 4; w++) exp_page[w] = '0;
    chk_all_windows("R1 reset map");
    chk("R1 reset irq", 32'(irq), 0);
  endtask

  task automatic t_load_all;
    for (int w = 0; w < 4; w++) begin
      cpu_write(16'h8000, 8'(w));
      chk_all_windows("R2 select no remap");
      cpu_write(16'h8001, 8'(8'h21 + w * 8'h32)); // odd values: bit 0 dropped (R5)
      exp_page[w] = 7'((8'h21 + w * 8'h32) >> 1);
    end
    chk_all_windows("R4 R5 window map");
    ppu_addr = 14'h3FFF;
    #0.5;
    chk("R4 bit13 ignored", 32'(chr_addr), 32'(exp_phys(14'h1FFF)));
  endtask

  task automatic t_index_persist;
    cpu_write(16'h8000, 8'hFD); // high bits set -> index 1 (R10)
    cpu_write(16'h8001, 8'h44);
    exp_page[1] = 7'h22;
    chk_all_windows("R10 index low bits");
    cpu_write(16'h8001, 8'h90);
    exp_page[1] = 7'h48;
    chk_all_windows("R3 index persists");
  endtask

  task automatic t_latency;
    ppu_addr = 14'h0123;
    cpu_write(16'h8000, 8'h00);
    @(negedge clk);
    cpu_addr = 16'h8001; cpu_data = 8'hF0; cpu_wr = 1'b1;
    #0.5;
    chk("R6 old before edge", 32'(chr_addr), 32'(exp_phys(ppu_addr)));
    @(negedge clk);
    cpu_wr = 1'b0;
    exp_page[0] = 7'h78;
    #0.5;
    chk("R6 new after edge", 32'(chr_addr), 32'(exp_phys(ppu_addr)));
  endtask

  task automatic t_ignored;
    @(negedge clk);
    cpu_addr = 16'h8001; cpu_data = 8'h0E; cpu_wr = 1'b0;
    @(negedge clk);
    chk_all_windows("R9 strobe low");
    cpu_write(16'h8002, 8'h0E);
    cpu_write(16'hA001, 8'h0E);
    cpu_write(16'h0001, 8'h0E);
    chk_all_windows("R9 other addr");
    cpu_write(16'h8001, 8'h02); // index must still be 0
    exp_page[0] = 7'h01;
    chk_all_windows("R9 index untouched");
    cpu_write(16'hE001, 8'h00);
    chk("R9 irq untouched", 32'(irq), 0);
  endtask

  task automatic t_irq;
    @(negedge clk); scanline = 1'b1;
    @(negedge clk); scanline = 1'b0;
    chk("R7 raise", 32'(irq), 1);
    repeat (5) @(negedge clk);
    cpu_write(16'h8000, 8'h01);
    chk("R7 hold", 32'(irq), 1);
    cpu_write(16'hE000, 8'h5A);
    chk("R8 ack clears", 32'(irq), 0);
    @(negedge clk);
    scanline = 1'b1; cpu_addr = 16'hE000; cpu_data = 8'hFF; cpu_wr = 1'b1;
    @(negedge clk);
    scanline = 1'b0; cpu_wr = 1'b0;
    chk("R8 pulse wins", 32'(irq), 1);
    cpu_write(16'hE000, 8'h00);
    chk("R8 ack zero data", 32'(irq), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_all();
    t_index_persist();
    t_latency();
    t_ignored();
    t_irq();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule